// File: doc/BRIEF.md
# Global Address Region Translator

This block sits on a processor's memory-request path, between the request port and the node's two exits: local memory and the network. Each 32-bit request address is compared against four programmable windows. An address inside an enabled window is a global virtual address. The block splits its offset from the window start into two parts: a destination node number and a physical address at that node, which receives a per-window base offset.

A translated request whose node equals the local node goes to the local memory exit. Any other node sends it to the network exit. An address that hits no window is a private local address. Several operating systems can share one memory this way, each starting at its own address 0. A private address below the configured local size is relocated by a per-node base and sent to local memory. One at or above that size is refused on a third, error exit and is not forwarded.

Translation sits behind one register stage. The input and all three exits use valid/ready handshakes. The three exits share one data bus, and at most one exit valid is high at a time.

Top module: `gart_top`

## Requirements
- R1: After reset the output stage is empty: `in_ready`=1 and all three exit valids are 0. Every window is disabled and the local size is 0, so any request is refused on the error exit.
- R2: Configuration writes are addressed by `cfg_addr`. With bit 4 = 0, bits [3:2] select the window and bits [1:0] the field: 0 = start, 1 = last address (inclusive), 2 = control (bit 0 enable, bits [12:8] node-select shift), 3 = physical base offset. Address 16 sets the local relocation base and address 17 sets the local size. A window matches when it is enabled and start <= address <= last. A disabled window never matches.
- R3: When several windows match, the lowest-numbered one is used.
- R4: For a matched window, with offs = address − start and s = shift: node = (offs >> s) truncated to 4 bits, and physical address = (offs mod 2^s) + base offset.
- R5: A translated request whose node equals `local_node` leaves on the memory exit with `out_remote`=0. Any other node leaves on the network exit with `out_remote`=1.
- R6: A request that matches no window and whose address is below the local size leaves on the memory exit. It carries address + local base, node = `local_node` and `out_remote`=0.
- R7: A request that matches no window and whose address is at or above the local size leaves only on the error exit, with its original address, `out_remote`=0 and its tag.
- R8: A request accepted at a clock edge appears on exactly one exit right after that edge, one cycle of latency. Tag and write flag travel with it, and order is preserved.
- R9: While the occupied exit is not ready, the output data and valid hold steady and `in_ready` is 0 whenever a new request is waiting.
- R10: At most one of `mem_valid`, `net_valid`, `err_valid` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_node | input | 4 | This node's number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 32 | Request physical address |
| in_write | input | 1 | Request is a write |
| in_tag | input | 4 | Request tag |
| mem_valid | output | 1 | Local memory exit valid |
| mem_ready | input | 1 | Local memory exit ready |
| net_valid | output | 1 | Network exit valid |
| net_ready | input | 1 | Network exit ready |
| err_valid | output | 1 | Error response valid |
| err_ready | input | 1 | Error response ready |
| out_node | output | 4 | Destination node |
| out_addr | output | 32 | Physical address at the destination (original address on error) |
| out_remote | output | 1 | 1 when the request goes to another node |
| out_write | output | 1 | Write flag of the request |
| out_tag | output | 4 | Tag of the request |

## Verification
Directed addresses cover each window's first and last byte, the overlap of windows 0 and 1, a disabled window, and the words just below and at the local size. These separate the priority, the bounds and the local-versus-error decisions. One window uses a shift whose node field wraps, and window 1 produces a local node, so node truncation and the memory/network split are told apart. A pseudo-random address stream then runs under random exit readiness to exercise ordering and backpressure. A held stall shows that the output holds steady and the input is blocked, and a late window enable shows that a reconfiguration takes effect.

// File: rtl/gart_pkg.sv
`timescale 1ns/1ps
package gart_pkg;
    localparam int ADDR_W    = 32;
    localparam int NODE_W    = 4;
    localparam int TAG_W     = 4;
    localparam int SHIFT_W   = 5;
    localparam int NUM_REG   = 4;
    localparam int IDX_W     = $clog2(NUM_REG);
    localparam int CFG_A_W   = IDX_W + 3;
    localparam int SHIFT_LSB = 8;

    localparam logic [1:0] FLD_START = 2'd0;
    localparam logic [1:0] FLD_LAST  = 2'd1;
    localparam logic [1:0] FLD_CTRL  = 2'd2;
    localparam logic [1:0] FLD_OFFS  = 2'd3;

    typedef enum logic [1:0] {
        RT_MEM = 2'd0,
        RT_NET = 2'd1,
        RT_ERR = 2'd2
    } route_e;

    typedef struct packed {
        logic               en;
        logic [SHIFT_W-1:0] shift;
        logic [ADDR_W-1:0]  start;
        logic [ADDR_W-1:0]  last;
        logic [ADDR_W-1:0]  offs;
    } window_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [TAG_W-1:0]  tag;
    } req_t;

    typedef struct packed {
        route_e            route;
        logic              remote;
        logic [NODE_W-1:0] node;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [TAG_W-1:0]  tag;
    } xres_t;

    function automatic logic [ADDR_W-1:0] low_mask(input logic [SHIFT_W-1:0] s);
        return (ADDR_W'(1) << s) - ADDR_W'(1);
    endfunction
endpackage

// File: rtl/gart_window_file.sv
`timescale 1ns/1ps
module gart_window_file
    import gart_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [CFG_A_W-1:0]        cfg_addr,
    input  logic [ADDR_W-1:0]         cfg_wdata,
    output window_t [NUM_REG-1:0]     tbl,
    output logic [ADDR_W-1:0]         loc_base,
    output logic [ADDR_W-1:0]         loc_size
);
    logic sel_global;
    assign sel_global = cfg_addr[CFG_A_W-1];

    for (genvar i = 0; i < NUM_REG; i++) begin : g_win
        window_t win_q;
        logic    hit_w;
        assign hit_w = cfg_we && !sel_global && (cfg_addr[IDX_W+1:2] == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                win_q <= '0;
            end else if (hit_w) begin
                case (cfg_addr[1:0])
                    FLD_START: win_q.start <= cfg_wdata;
                    FLD_LAST:  win_q.last  <= cfg_wdata;
                    FLD_CTRL: begin
                        win_q.en    <= cfg_wdata[0];
                        win_q.shift <= cfg_wdata[SHIFT_LSB +: SHIFT_W];
                    end
                    default:   win_q.offs  <= cfg_wdata;
                endcase
            end
        end
        assign tbl[i] = win_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_base <= '0;
            loc_size <= '0;
        end else if (cfg_we && sel_global) begin
            if (cfg_addr[CFG_A_W-2:0] == '0)
                loc_base <= cfg_wdata;
            else if (cfg_addr[CFG_A_W-2:0] == (CFG_A_W-1)'(1))
                loc_size <= cfg_wdata;
        end
    end
endmodule

// File: rtl/gart_match.sv
`timescale 1ns/1ps
module gart_match
    import gart_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  window_t [NUM_REG-1:0] tbl,
    output logic                  hit,
    output logic [IDX_W-1:0]      idx
);
    logic [NUM_REG-1:0] hv;

    for (genvar i = 0; i < NUM_REG; i++) begin : g_cmp
        assign hv[i] = tbl[i].en && (addr >= tbl[i].start) && (addr <= tbl[i].last);
    end

    always_comb begin
        hit = |hv;
        idx = '0;
        for (int i = NUM_REG - 1; i >= 0; i--) begin
            if (hv[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/gart_xlate.sv
`timescale 1ns/1ps
module gart_xlate
    import gart_pkg::*;
(
    input  req_t              req,
    input  logic              hit,
    input  window_t           win,
    input  logic [ADDR_W-1:0] loc_base,
    input  logic [ADDR_W-1:0] loc_size,
    input  logic [NODE_W-1:0] local_node,
    output xres_t             res
);
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] shifted;
    logic [NODE_W-1:0] node;
    logic [ADDR_W-1:0] phys;

    always_comb begin
        offs    = req.addr - win.start;
        shifted = offs >> win.shift;
        node    = shifted[NODE_W-1:0];
        phys    = (offs & low_mask(win.shift)) + win.offs;

        res.write = req.write;
        res.tag   = req.tag;
        if (hit) begin
            res.node   = node;
            res.addr   = phys;
            res.remote = (node != local_node);
            res.route  = (node != local_node) ? RT_NET : RT_MEM;
        end else if (req.addr < loc_size) begin
            res.node   = local_node;
            res.addr   = req.addr + loc_base;
            res.remote = 1'b0;
            res.route  = RT_MEM;
        end else begin
            res.node   = local_node;
            res.addr   = req.addr;
            res.remote = 1'b0;
            res.route  = RT_ERR;
        end
    end
endmodule

// File: rtl/gart_top.sv
`timescale 1ns/1ps
module gart_top
    import gart_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NODE_W-1:0]   local_node,
    input  logic                cfg_we,
    input  logic [CFG_A_W-1:0]  cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic                in_write,
    input  logic [TAG_W-1:0]    in_tag,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                net_valid,
    input  logic                net_ready,
    output logic                err_valid,
    input  logic                err_ready,
    output logic [NODE_W-1:0]   out_node,
    output logic [ADDR_W-1:0]   out_addr,
    output logic                out_remote,
    output logic                out_write,
    output logic [TAG_W-1:0]    out_tag
);
    window_t [NUM_REG-1:0] tbl;
    logic [ADDR_W-1:0]     loc_base;
    logic [ADDR_W-1:0]     loc_size;
    logic                  hit;
    logic [IDX_W-1:0]      idx;
    req_t                  req;
    xres_t                 res;
    xres_t                 stage_q;
    logic                  valid_q;
    logic                  drain;
    logic                  take;

    gart_window_file u_wfile (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tbl(tbl), .loc_base(loc_base), .loc_size(loc_size)
    );

    gart_match u_match (.addr(in_addr), .tbl(tbl), .hit(hit), .idx(idx));

    assign req = '{addr: in_addr, write: in_write, tag: in_tag};

    gart_xlate u_xlate (
        .req(req), .hit(hit), .win(tbl[idx]), .loc_base(loc_base),
        .loc_size(loc_size), .local_node(local_node), .res(res)
    );

    assign mem_valid = valid_q && (stage_q.route == RT_MEM);
    assign net_valid = valid_q && (stage_q.route == RT_NET);
    assign err_valid = valid_q && (stage_q.route == RT_ERR);
    assign drain     = (mem_valid && mem_ready) || (net_valid && net_ready) ||
                       (err_valid && err_ready);
    assign in_ready  = !valid_q || drain;
    assign take      = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            stage_q <= '0;
        end else begin
            if (take) begin
                valid_q <= 1'b1;
                stage_q <= res;
            end else if (drain) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_node   = stage_q.node;
    assign out_addr   = stage_q.addr;
    assign out_remote = stage_q.remote;
    assign out_write  = stage_q.write;
    assign out_tag    = stage_q.tag;

    p_one_exit_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_valid, net_valid, err_valid}));

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (mem_valid || net_valid || err_valid));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((mem_valid || net_valid || err_valid) && !in_ready) |=>
            ($stable(out_addr) && $stable(out_tag) && $stable(out_node) &&
             (mem_valid || net_valid || err_valid)));

    p_net_remote_r5: assert property (@(posedge clk) disable iff (rst)
        net_valid |-> out_remote);

    p_mem_local_r5: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (!out_remote && out_node == local_node));

    p_err_local_r7: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> !out_remote);
endmodule

// File: tb/test_gart_top.sv
`timescale 1ns/1ps
module test_gart_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  local_node = 4'd3;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        in_write = 1'b0;
    logic [3:0]  in_tag = '0;
    logic        mem_valid, net_valid, err_valid;
    logic        mem_ready = 1'b1, net_ready = 1'b1, err_ready = 1'b1;
    logic [3:0]  out_node;
    logic [31:0] out_addr;
    logic        out_remote, out_write;
    logic [3:0]  out_tag;

    int total = 0;
    int bad = 0;
    int ready_mode = 0;
    logic [3:0]  tag_ctr = '0;
    logic [31:0] rseed = 32'h1234_5678;
    logic [31:0] aseed = 32'hCAFE_F00D;

    logic [31:0] sh_start [4];
    logic [31:0] sh_last  [4];
    logic [31:0] sh_offs  [4];
    logic [4:0]  sh_shift [4];
    logic        sh_en    [4];
    logic [31:0] sh_lbase = '0;
    logic [31:0] sh_lsize = '0;

    typedef struct {
        int          route;
        logic [3:0]  node;
        logic [31:0] addr;
        logic        remote;
        logic        write;
        logic [3:0]  tag;
    } exp_t;
    exp_t sb[$];

    gart_top i_gart_top (
        .clk(clk), .rst(rst), .local_node(local_node), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .in_write(in_write), .in_tag(in_tag),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .net_valid(net_valid),
        .net_ready(net_ready), .err_valid(err_valid), .err_ready(err_ready),
        .out_node(out_node), .out_addr(out_addr), .out_remote(out_remote),
        .out_write(out_write), .out_tag(out_tag)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model built from R2..R7
    function automatic exp_t model(input logic [31:0] a, input logic w, input logic [3:0] t);
        exp_t e;
        int   w_i;
        logic [31:0] o;
        w_i = -1;
        for (int i = 3; i >= 0; i--)
            if (sh_en[i] && a >= sh_start[i] && a <= sh_last[i]) w_i = i;
        e.write = w;
        e.tag   = t;
        if (w_i >= 0) begin
            o        = a - sh_start[w_i];
            e.node   = 4'((o >> sh_shift[w_i]) & 32'hF);
            e.addr   = (o & ((32'h1 << sh_shift[w_i]) - 32'h1)) + sh_offs[w_i];
            e.remote = (e.node != local_node);
            e.route  = e.remote ? 1 : 0;
        end else if (a < sh_lsize) begin
            e.node = local_node; e.addr = a + sh_lbase; e.remote = 1'b0; e.route = 0;
        end else begin
            e.node = local_node; e.addr = a; e.remote = 1'b0; e.route = 2;
        end
        return e;
    endfunction

    task automatic cfg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #0.2;
        cfg_we = 1'b0;
        if (a == 5'd16) sh_lbase = d;
        else if (a == 5'd17) sh_lsize = d;
        else if (a[4] == 1'b0) begin
            case (a[1:0])
                2'd0: sh_start[a[3:2]] = d;
                2'd1: sh_last[a[3:2]]  = d;
                2'd2: begin sh_en[a[3:2]] = d[0]; sh_shift[a[3:2]] = d[12:8]; end
                default: sh_offs[a[3:2]] = d;
            endcase
        end
    endtask

    task automatic send(input logic [31:0] a, input logic w);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_write = w; in_tag = tag_ctr;
        #0.5;
        while (!in_ready) begin
            @(negedge clk); #0.5;
        end
        sb.push_back(model(a, w, tag_ctr));
        @(posedge clk); #0.2;
        in_valid = 1'b0;
        tag_ctr++;
    endtask

    // Exit readiness: 0 all ready, 1 pseudo-random, 2 none
    always @(negedge clk) begin
        rseed = xs(rseed);
        case (ready_mode)
            0: begin mem_ready = 1; net_ready = 1; err_ready = 1; end
            1: begin mem_ready = rseed[3]; net_ready = rseed[9]; err_ready = rseed[17]; end
            default: begin mem_ready = 0; net_ready = 0; err_ready = 0; end
        endcase
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (!rst && ((mem_valid && mem_ready) || (net_valid && net_ready) ||
                     (err_valid && err_ready))) begin
            check("R10", "one exit valid", 32'(mem_valid + net_valid + err_valid), 32'd1);
            if (sb.size() == 0) begin
                check("R8", "unexpected output", 32'd1, 32'd0);
            end else begin
                exp_t e;
                int   r;
                e = sb.pop_front();
                r = mem_valid ? 0 : (net_valid ? 1 : 2);
                check("R5/R6/R7", "exit", 32'(r), 32'(e.route));
                check("R8", "tag", 32'(out_tag), 32'(e.tag));
                check("R8", "write", 32'(out_write), 32'(e.write));
                check("R4/R6", "addr", out_addr, e.addr);
                check("R4", "node", 32'(out_node), 32'(e.node));
                check("R5", "remote", 32'(out_remote), 32'(e.remote));
            end
        end
    end

    task automatic drain_sb();
        int n;
        n = 0;
        while (sb.size() != 0 && n < 2000) begin
            @(negedge clk); n++;
        end
        check("R8", "scoreboard drained", 32'(sb.size()), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        for (int i = 0; i < 4; i++) begin
            sh_start[i] = '0; sh_last[i] = '0; sh_offs[i] = '0; sh_shift[i] = '0; sh_en[i] = 0;
        end
        repeat (3) @(posedge clk);
        #0.2 rst = 1'b0;
        @(negedge clk); #0.5;
        // R1: reset state
        check("R1", "in_ready", 32'(in_ready), 32'd1);
        check("R1", "valids", 32'({mem_valid, net_valid, err_valid}), 32'd0);
        send(32'h0000_0000, 1'b0);   // R1: no windows, zero size -> error
        drain_sb();

        cfg(5'd0,  32'h8000_0000); cfg(5'd1,  32'h8FFF_FFFF);
        cfg(5'd2,  32'h0000_1801); cfg(5'd3,  32'h0010_0000);
        cfg(5'd4,  32'h8800_0000); cfg(5'd5,  32'h9FFF_FFFF);
        cfg(5'd6,  32'h0000_1401); cfg(5'd7,  32'h0000_0000);
        cfg(5'd8,  32'hA000_0000); cfg(5'd9,  32'hAFFF_FFFF);
        cfg(5'd10, 32'h0000_0800); cfg(5'd11, 32'h0000_4000);
        cfg(5'd12, 32'hB000_0000); cfg(5'd13, 32'hB0FF_FFFF);
        cfg(5'd14, 32'h0000_1001); cfg(5'd15, 32'h0000_0200);
        cfg(5'd16, 32'h0100_0000); cfg(5'd17, 32'h1000_0000);

        // Directed patterns (R2..R7)
        send(32'h8312_3456, 1'b1);   // R4/R5 window0 node 3 local
        send(32'h8512_3456, 1'b0);   // R5 node 5 remote
        send(32'h8A00_0010, 1'b0);   // R3 overlap, window0 wins
        send(32'h9234_5678, 1'b1);   // R4 window1 node wraps to local 3
        send(32'h8000_0000, 1'b0);   // R2 first byte
        send(32'h9FFF_FFFF, 1'b0);   // R2 last byte
        send(32'h0000_1000, 1'b1);   // R6 relocation
        send(32'h0FFF_FFFF, 1'b0);   // R6 just below size
        send(32'h1000_0000, 1'b0);   // R7 at size
        send(32'hA000_0000, 1'b0);   // R2 disabled window -> R7
        send(32'hB012_3456, 1'b0);   // R4 shift 16
        drain_sb();

        // R9: stall with held exits
        ready_mode = 2;
        send(32'h8512_0000, 1'b0);
        @(negedge clk); #0.5;
        check("R8", "valid after one cycle", 32'(net_valid), 32'd1);
        held = out_addr;
        in_valid = 1'b1; in_addr = 32'h0000_2000; in_tag = 4'hF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #0.5;
            check("R9", "in_ready blocked", 32'(in_ready), 32'd0);
            check("R9", "output held", out_addr, held);
            check("R9", "valid held", 32'(net_valid), 32'd1);
        end
        in_valid = 1'b0;
        ready_mode = 0;
        drain_sb();

        // R2: enabling window2 changes the outcome
        cfg(5'd10, 32'h0000_0801);
        send(32'hA000_0000, 1'b1);
        send(32'hA000_3000, 1'b0);
        drain_sb();

        // Mixed stream under random readiness (R8 ordering, R9)
        ready_mode = 1;
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            aseed = xs(aseed);
            case (aseed[31:30])
                2'd0: a = {4'h8, aseed[27:0]};
                2'd1: a = {4'h9, aseed[27:0]};
                2'd2: a = {4'h0, aseed[27:0]};
                default: a = aseed;
            endcase
            send(a, aseed[5]);
        end
        ready_mode = 0;
        drain_sb();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule